// File: doc/BRIEF.md
# SPI Word Shifter with Master and Slave Roles

This block moves whole words between a pair of word queues and a four-wire serial link, in either direction at once. A word is taken from the transmit queue, loaded into a shift register and sent out one bit per serial clock period. At the same time the bits arriving on the serial input are collected into a word, and that word is handed to the receive queue. The serial clock itself is not made here. A separate generator supplies one-cycle strobes that mark each rising and each falling serial clock edge. In master mode that generator divides the system clock. In slave mode it detects the edges of the incoming clock.

One control engine serves both roles, and `cfgMaster` picks between them. As master, the block starts when software raises a start command and the transmit queue holds data. It keeps its chip-select output low while words follow one another. As slave, an incoming active-low select gates the transfer, and the clock polarity and phase come from their own slave-side inputs. The bit order can be set either way, and the word width is a parameter.

Top module: `spi_xfer_engine`

## Requirements
- R1: While reset is held, and after reset with no activity, `csOutN` is 1, `txPop` and `rxPush` are 0 and `overflow` is 0.
- R2: In master mode (`cfgMaster`=1), a transfer begins only when `startCmd` is 1 and `txEmpty` is 0. Each word pops exactly one entry, and `csOutN` is 0 whenever a pop happens.
- R3: The leading edge is the rising strobe when polarity is 0 and the falling strobe when polarity is 1. With phase 0, `sdi` is sampled on leading edges and `sdo` advances on trailing edges, and the first bit is present before the first edge. With phase 1, `sdo` advances on leading edges (except the first) and `sdi` is sampled on trailing edges.
- R4: With `cfgLsbFirst`=0, `sdo` sends bit WIDTH-1 first, and the first received bit lands in bit WIDTH-1. With `cfgLsbFirst`=1, both start from bit 0.
- R5: After WIDTH samples, the assembled word appears on `rxData` with a one-cycle `rxPush`, and `rxPush` never coincides with `txPop`.
- R6: If `rxFull` is 1 when a word completes, the word is dropped with no push. `overflow` then becomes 1 and stays 1 until reset.
- R7: In master mode, `csOutN` stays 0 without a gap from one word to the next while the transmit queue still holds data. It returns to 1 after the last word.
- R8: In slave mode (`cfgMaster`=0), a low `slvCsN` starts the transfer. Polarity and phase come from `slvCpol`/`slvCpha`, while `cfgCpol`, `cfgCpha` and `startCmd` have no effect, and `csOutN` stays 1. In master mode `slvCsN` has no effect.
- R9: In slave mode, `slvCsN` going high in the middle of a word abandons that word with no push. The next word starts from bit zero.
- R10: In slave mode with an empty transmit queue, the block sends all-zero words and does not pop.
- R11: `txPop` is never asserted while `txEmpty` is 1, and `rxPush` is never asserted while `rxFull` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgMaster | input | 1 | 1 selects master role, 0 slave role |
| cfgCpol | input | 1 | Clock polarity used in master role |
| cfgCpha | input | 1 | Clock phase used in master role |
| cfgLsbFirst | input | 1 | 1 shifts least significant bit first |
| startCmd | input | 1 | Master transfer enable |
| slvCsN | input | 1 | Incoming active-low select in slave role |
| slvCpol | input | 1 | Clock polarity used in slave role |
| slvCpha | input | 1 | Clock phase used in slave role |
| edgeRise | input | 1 | One-cycle strobe for a rising serial clock edge |
| edgeFall | input | 1 | One-cycle strobe for a falling serial clock edge |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| csOutN | output | 1 | Active-low select driven in master role |
| txEmpty | input | 1 | Transmit queue has no word |
| txData | input | WIDTH | Head word of transmit queue |
| txPop | output | 1 | Consume head of transmit queue |
| rxFull | input | 1 | Receive queue cannot accept a word |
| rxData | output | WIDTH | Completed received word |
| rxPush | output | 1 | Write `rxData` into receive queue |
| overflow | output | 1 | Sticky: a received word was dropped |

## Verification
The assertions check, on every cycle, the queue handshake rules: no pop from an empty queue and no push into a full one. They also check that a push and a pop never fall in the same cycle, that the overflow flag is sticky and rises only when the receive queue is full, that a master pop happens only with the select low, and that the select output stays high in slave mode. The bench scenarios are needed for the serial behaviour: which edge samples and which edge shifts for each polarity and phase, the bit order of both the sent and the received words, and whether the slave-side settings are used in place of the master ones. They also cover the unbroken select across back-to-back words, abandoning a word when the slave select drops, and sending zeros from an empty queue.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DONE  = 2'd3
  } engState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // take a new transmit word
    logic loadZero;  // load zeros instead (queue empty)
    logic sample;    // capture sdi
    logic drive;     // advance sdo to the next bit
  } dpCtrl_t;

endpackage

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cfgMaster,
  input  logic    cfgCpol,
  input  logic    cfgCpha,
  input  logic    startCmd,
  input  logic    slvCsN,
  input  logic    slvCpol,
  input  logic    slvCpha,
  input  logic    edgeRise,
  input  logic    edgeFall,
  input  logic    txEmpty,
  input  logic    rxFull,
  output dpCtrl_t ctl,
  output logic    txPop,
  output logic    rxPush,
  output logic    csOutN,
  output logic    overflow
);

  localparam int CNT_W = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WIDTH - 1);

  engState_t        state, stateNext;
  logic [CNT_W-1:0] bitCnt;

  logic effPol, effPha;
  logic leadEdge, trailEdge, sampleEdge, driveEdge;
  logic slvGone, lastSample, moreWork;

  // the active role picks its polarity and phase source
  always_comb begin
    effPol     = cfgMaster ? cfgCpol : slvCpol;
    effPha     = cfgMaster ? cfgCpha : slvCpha;
    leadEdge   = effPol ? edgeFall : edgeRise;
    trailEdge  = effPol ? edgeRise : edgeFall;
    sampleEdge = effPha ? trailEdge : leadEdge;
    driveEdge  = effPha ? leadEdge : trailEdge;
    slvGone    = !cfgMaster && slvCsN;
    lastSample = sampleEdge && (bitCnt == LAST_BIT);
    moreWork   = cfgMaster ? !txEmpty : !slvCsN;
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (cfgMaster ? (startCmd && !txEmpty) : !slvCsN) stateNext = ST_LOAD;
      end
      ST_LOAD: begin
        stateNext = slvGone ? ST_IDLE : ST_SHIFT;
      end
      ST_SHIFT: begin
        if (slvGone)         stateNext = ST_IDLE;
        else if (lastSample) stateNext = ST_DONE;
      end
      ST_DONE: begin
        stateNext = moreWork ? ST_LOAD : ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      state <= stateNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
    end else if (state == ST_LOAD) begin
      bitCnt <= '0;
    end else if (ctl.sample) begin
      bitCnt <= bitCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overflow <= 1'b0;
    end else if (state == ST_DONE && rxFull) begin
      overflow <= 1'b1;
    end
  end

  // the first drive edge of a word (bitCnt zero) keeps bit zero in place
  always_comb begin
    ctl.load     = (state == ST_LOAD);
    ctl.loadZero = txEmpty;
    ctl.sample   = (state == ST_SHIFT) && sampleEdge && !slvGone;
    ctl.drive    = (state == ST_SHIFT) && driveEdge && !slvGone && (bitCnt != '0);
    txPop        = (state == ST_LOAD) && !txEmpty;
    rxPush       = (state == ST_DONE) && !rxFull;
    csOutN       = !(cfgMaster && (state != ST_IDLE));
  end

endmodule

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctl,
  input  logic             cfgLsbFirst,
  input  logic [WIDTH-1:0] txData,
  input  logic             sdi,
  output logic             sdo,
  output logic [WIDTH-1:0] rxData
);

  logic [WIDTH-1:0] txSh;
  logic [WIDTH-1:0] rxSh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
    end else if (ctl.load) begin
      txSh <= ctl.loadZero ? '0 : txData;
    end else if (ctl.drive) begin
      txSh <= cfgLsbFirst ? (txSh >> 1) : (txSh << 1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxSh <= '0;
    end else if (ctl.sample) begin
      rxSh <= cfgLsbFirst ? {sdi, rxSh[WIDTH-1:1]} : {rxSh[WIDTH-2:0], sdi};
    end
  end

  assign sdo    = cfgLsbFirst ? txSh[0] : txSh[WIDTH-1];
  assign rxData = rxSh;

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
  import spi_eng_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgMaster,
  input  logic             cfgCpol,
  input  logic             cfgCpha,
  input  logic             cfgLsbFirst,
  input  logic             startCmd,
  input  logic             slvCsN,
  input  logic             slvCpol,
  input  logic             slvCpha,
  input  logic             edgeRise,
  input  logic             edgeFall,
  input  logic             sdi,
  output logic             sdo,
  output logic             csOutN,
  input  logic             txEmpty,
  input  logic [WIDTH-1:0] txData,
  output logic             txPop,
  input  logic             rxFull,
  output logic [WIDTH-1:0] rxData,
  output logic             rxPush,
  output logic             overflow
);

  dpCtrl_t ctl;

  spi_eng_ctrl #(.WIDTH(WIDTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgMaster(cfgMaster),
    .cfgCpol  (cfgCpol),
    .cfgCpha  (cfgCpha),
    .startCmd (startCmd),
    .slvCsN   (slvCsN),
    .slvCpol  (slvCpol),
    .slvCpha  (slvCpha),
    .edgeRise (edgeRise),
    .edgeFall (edgeFall),
    .txEmpty  (txEmpty),
    .rxFull   (rxFull),
    .ctl      (ctl),
    .txPop    (txPop),
    .rxPush   (rxPush),
    .csOutN   (csOutN),
    .overflow (overflow)
  );

  spi_eng_dp #(.WIDTH(WIDTH)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .cfgLsbFirst(cfgLsbFirst),
    .txData     (txData),
    .sdi        (sdi),
    .sdo        (sdo),
    .rxData     (rxData)
  );

endmodule

// File: rtl/spi_xfer_engine_chk.sv
module spi_xfer_engine_chk (
  input logic clk,
  input logic rstN,
  input logic cfgMaster,
  input logic csOutN,
  input logic txEmpty,
  input logic txPop,
  input logic rxFull,
  input logic rxPush,
  input logic overflow
);

  assert_pop_nonempty_R11: assert property (@(posedge clk) disable iff (!rstN)
    txPop |-> !txEmpty);

  assert_push_notfull_R11: assert property (@(posedge clk) disable iff (!rstN)
    rxPush |-> !rxFull);

  assert_push_pop_apart_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(rxPush && txPop));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  assert_ovf_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(overflow) |-> $past(rxFull));

  assert_master_pop_cs_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMaster && txPop) |-> !csOutN);

  assert_slave_cs_high_R8: assert property (@(posedge clk) disable iff (!rstN)
    !cfgMaster |-> csOutN);

endmodule

bind spi_xfer_engine spi_xfer_engine_chk uChk (
  .clk      (clk),
  .rstN     (rstN),
  .cfgMaster(cfgMaster),
  .csOutN   (csOutN),
  .txEmpty  (txEmpty),
  .txPop    (txPop),
  .rxFull   (rxFull),
  .rxPush   (rxPush),
  .overflow (overflow)
);

// File: tb/spi_xfer_engine_test.sv
`timescale 1ns/1ps
module spi_xfer_engine_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgMaster = 1'b1, cfgCpol = 1'b0, cfgCpha = 1'b0, cfgLsbFirst = 1'b0;
  logic startCmd = 1'b0, slvCsN = 1'b1, slvCpol = 1'b0, slvCpha = 1'b0;
  logic edgeRise = 1'b0, edgeFall = 1'b0, sdi = 1'b0, rxFull = 1'b0;
  logic sdo, csOutN, txPop, rxPush, overflow, txEmpty;
  logic [7:0] txData, rxData;

  always #2.5 clk = ~clk;

  // transmit queue model: bench writes, pop advances read pointer
  logic [7:0] txMem [16];
  int txWr = 0;
  int txRd = 0;
  int pushCnt = 0;
  logic [7:0] lastRx = '0;
  assign txEmpty = (txWr == txRd);
  assign txData  = txMem[txRd[3:0]];

  always @(posedge clk) begin
    if (txPop) txRd <= txRd + 1;
    if (rxPush) begin
      pushCnt <= pushCnt + 1;
      lastRx  <= rxData;
    end
  end

  logic watchCs = 1'b0;
  logic csGap = 1'b0;
  always @(negedge clk) if (watchCs && csOutN) csGap = 1'b1;

  spi_xfer_engine #(.WIDTH(8)) uut (
    .clk(clk), .rstN(rstN), .cfgMaster(cfgMaster), .cfgCpol(cfgCpol),
    .cfgCpha(cfgCpha), .cfgLsbFirst(cfgLsbFirst), .startCmd(startCmd),
    .slvCsN(slvCsN), .slvCpol(slvCpol), .slvCpha(slvCpha),
    .edgeRise(edgeRise), .edgeFall(edgeFall), .sdi(sdi), .sdo(sdo),
    .csOutN(csOutN), .txEmpty(txEmpty), .txData(txData), .txPop(txPop),
    .rxFull(rxFull), .rxData(rxData), .rxPush(rxPush), .overflow(overflow)
  );

  int errs = 0;
  int checks = 0;
  logic finished = 1'b0;

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic isRise);
    if (isRise) edgeRise = 1'b1; else edgeFall = 1'b1;
    @(negedge clk);
    edgeRise = 1'b0;
    edgeFall = 1'b0;
  endtask

  // acts as the far end plus clock generator; entered at a negedge
  task automatic runWord(input logic p, input logic h, input logic l,
                         input logic [7:0] sw, input int nb, output logic [7:0] got);
    got = '0;
    for (int k = 0; k < nb; k++) begin
      automatic int bk = l ? k : 7 - k;
      if (!h) begin
        sdi = sw[bk];
        got[bk] = sdo;
        pulse(!p);
        waitN(2);
        pulse(p);
        waitN(2);
      end else begin
        pulse(!p);
        waitN(2);
        sdi = sw[bk];
        got[bk] = sdo;
        pulse(p);
        waitN(2);
      end
    end
  endtask

  task automatic pushTx(input logic [7:0] w);
    txMem[txWr[3:0]] = w;
    txWr++;
  endtask

  // {master, pol, pha, lsbFirst, txWord, sdiWord}
  localparam logic [19:0] VEC [8] = '{
    {4'b1000, 8'hC4, 8'h6B},
    {4'b1101, 8'h1E, 8'hD2},
    {4'b1011, 8'h72, 8'h17},
    {4'b1110, 8'hB3, 8'h4C},
    {4'b0001, 8'h0D, 8'hF1},
    {4'b0100, 8'hE8, 8'h38},
    {4'b0010, 8'h59, 8'h8E},
    {4'b0111, 8'h26, 8'hA3}
  };

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] got;
    int pre, preRd;

    // R1: reset state
    waitN(2);
    check(csOutN == 1'b1 && !txPop && !rxPush && !overflow, "R1 in reset",
          {csOutN, txPop, rxPush, overflow}, 4'b1000);
    rstN = 1'b1;
    waitN(3);
    check(csOutN == 1'b1, "R1 csOutN idle", csOutN, 1);
    check(!txPop && !rxPush, "R1 no handshake", {txPop, rxPush}, 0);
    check(overflow == 1'b0, "R1 overflow clear", overflow, 0);

    // R2: start with empty queue does nothing
    startCmd = 1'b1;
    waitN(5);
    check(csOutN == 1'b1, "R2 start on empty queue", csOutN, 1);
    startCmd = 1'b0;

    // R2/R8: data present but no start, slave select low in master mode
    pushTx(8'h5C);
    slvCsN = 1'b0;
    waitN(5);
    check(csOutN == 1'b1 && txRd == 0, "R2 R8 no start no pop", {csOutN, txRd[3:0]}, 5'h10);
    slvCsN = 1'b1;
    startCmd = 1'b1;
    waitN(3);
    check(csOutN == 1'b0, "R2 select low after start", csOutN, 0);
    runWord(1'b0, 1'b0, 1'b0, 8'h93, 8, got);
    waitN(3);
    startCmd = 1'b0;
    check(got == 8'h5C, "R2 R4 first word sent", got, 8'h5C);
    check(lastRx == 8'h93 && pushCnt == 1, "R5 first word received", lastRx, 8'h93);
    check(txRd == 1, "R2 one pop per word", txRd, 1);

    // table of role, polarity, phase and bit order cases
    foreach (VEC[i]) begin
      automatic logic m = VEC[i][19];
      automatic logic p = VEC[i][18];
      automatic logic h = VEC[i][17];
      automatic logic l = VEC[i][16];
      automatic logic [7:0] tw = VEC[i][15:8];
      automatic logic [7:0] sw = VEC[i][7:0];
      cfgMaster = m;
      cfgLsbFirst = l;
      if (m) begin
        cfgCpol = p; cfgCpha = h; slvCpol = !p; slvCpha = !h;
      end else begin
        slvCpol = p; slvCpha = h; cfgCpol = !p; cfgCpha = !h;
      end
      pushTx(tw);
      pre = pushCnt;
      if (m) startCmd = 1'b1; else slvCsN = 1'b0;
      waitN(3);
      runWord(p, h, l, sw, 8, got);
      waitN(3);
      startCmd = 1'b0;
      slvCsN = 1'b1;
      waitN(3);
      check(got == tw, $sformatf("R3 R4 R8 vec%0d sdo word", i), got, tw);
      check(lastRx == sw && pushCnt == pre + 1, $sformatf("R3 R4 R5 vec%0d rx word", i), lastRx, sw);
      check(txRd == txWr && csOutN == 1'b1, $sformatf("R2 R8 vec%0d pop and select", i),
            {csOutN, txRd[3:0]}, {1'b1, txWr[3:0]});
    end

    // R7: back-to-back words keep select low
    cfgMaster = 1'b1; cfgCpol = 1'b0; cfgCpha = 1'b1; cfgLsbFirst = 1'b0;
    pushTx(8'h3D);
    pushTx(8'hA6);
    pre = pushCnt;
    startCmd = 1'b1;
    waitN(3);
    csGap = 1'b0;
    watchCs = 1'b1;
    runWord(1'b0, 1'b1, 1'b0, 8'h71, 8, got);
    watchCs = 1'b0;
    check(got == 8'h3D, "R7 first of pair", got, 8'h3D);
    check(csGap == 1'b0, "R7 select held between words", csGap, 0);
    check(pushCnt == pre + 1 && lastRx == 8'h71, "R7 first rx", lastRx, 8'h71);
    runWord(1'b0, 1'b1, 1'b0, 8'hC9, 8, got);
    waitN(3);
    startCmd = 1'b0;
    check(got == 8'hA6, "R7 second of pair", got, 8'hA6);
    check(pushCnt == pre + 2 && lastRx == 8'hC9, "R7 second rx", lastRx, 8'hC9);
    check(csOutN == 1'b1, "R7 select released after last", csOutN, 1);

    // R8: slave ignores startCmd
    cfgMaster = 1'b0; slvCpol = 1'b1; slvCpha = 1'b0; cfgCpol = 1'b0; cfgCpha = 1'b1;
    cfgLsbFirst = 1'b1;
    pushTx(8'h4B);
    preRd = txRd;
    startCmd = 1'b1;
    waitN(5);
    check(txRd == preRd && csOutN == 1'b1, "R8 start ignored in slave", txRd - preRd, 0);
    startCmd = 1'b0;

    // R9: abort mid-word
    pre = pushCnt;
    slvCsN = 1'b0;
    waitN(3);
    runWord(1'b1, 1'b0, 1'b1, 8'hFF, 3, got);
    slvCsN = 1'b1;
    waitN(5);
    check(pushCnt == pre, "R9 abandoned word not pushed", pushCnt - pre, 0);
    check(txRd == txWr, "R9 word popped at load", txRd, txWr);

    // R10 and R9: fresh word after abort, empty queue sends zeros
    preRd = txRd;
    slvCsN = 1'b0;
    waitN(3);
    runWord(1'b1, 1'b0, 1'b1, 8'h5A, 8, got);
    waitN(2);
    slvCsN = 1'b1;
    waitN(3);
    check(got == 8'h00, "R10 zeros from empty queue", got, 0);
    check(txRd == preRd, "R10 no pop when empty", txRd - preRd, 0);
    check(lastRx == 8'h5A && pushCnt == pre + 1, "R9 restart from bit zero", lastRx, 8'h5A);

    // R6: overflow on full receive queue
    cfgMaster = 1'b1; cfgCpol = 1'b1; cfgCpha = 1'b1; cfgLsbFirst = 1'b0;
    pushTx(8'h17);
    pre = pushCnt;
    rxFull = 1'b1;
    startCmd = 1'b1;
    waitN(3);
    runWord(1'b1, 1'b1, 1'b0, 8'hE2, 8, got);
    waitN(3);
    startCmd = 1'b0;
    check(pushCnt == pre, "R6 no push when full", pushCnt - pre, 0);
    check(overflow == 1'b1, "R6 overflow set", overflow, 1);
    rxFull = 1'b0;
    pushTx(8'h68);
    startCmd = 1'b1;
    waitN(3);
    runWord(1'b1, 1'b1, 1'b0, 8'h2F, 8, got);
    waitN(3);
    startCmd = 1'b0;
    check(pushCnt == pre + 1 && lastRx == 8'h2F, "R6 push resumes", lastRx, 8'h2F);
    check(overflow == 1'b1, "R6 overflow sticky", overflow, 1);
    check(got == 8'h68, "R3 pol1 pha1 word", got, 8'h68);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule